// File: doc/BRIEF.md
# Masked Address Region Match Detector

This block watches the memory cycles of a processor bus and flags those that fall inside one programmable address region. Software programs a base register and a mask register. Within the compared address field, each mask bit set to 1 turns the matching base bit into a don't-care. Each mask bit left at 0 requires the cycle address to equal the base bit. Two control bits in the mask register choose whether read cycles, write cycles, both or neither can produce a hit.

A qualifying cycle produces a registered pulse one clock wide. Downstream logic uses that pulse to set an event bit in a status packet sent to a companion device. Both registers clear on reset, so the detector stays silent until software programs it.

Top module: `region_match_top`

## Requirements
- R1: After reset both registers read back as zero, `region_hit` is low, and no read or write cycle at any address produces a hit.
- R2: A write with `reg_sel`=0 stores bits 27:2 of `reg_wdata` into the base register. Base bits 31:28 and 1:0 always read as zero. The base register changes only on such a write.
- R3: A write with `reg_sel`=1 stores bits 27:0 of `reg_wdata` into the mask register. Mask bits 31:28 always read as zero. The mask register changes only on such a write.
- R4: Within bits 27:2, every address bit whose mask bit (same position) is 0 must equal the base bit for a hit. A single differing bit suppresses the hit.
- R5: Within bits 27:2, an address bit whose mask bit is 1 never prevents a hit.
- R6: A write cycle (`cyc_write`=1) can hit only while mask bit 1 (write enable) is 1.
- R7: A read cycle (`cyc_write`=0) can hit only while mask bit 0 (read enable) is 1.
- R8: Cycle address bits 31:28 and 1:0 take no part in the comparison.
- R9: `region_hit` rises on the clock edge after a qualifying cycle is sampled with `cyc_valid`=1. It lasts one clock per such cycle. It never rises for a cycle presented with `cyc_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select for write and read: 0 = base, 1 = mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read-back of the register chosen by `reg_sel` |
| cyc_valid | input | 1 | Bus cycle present this clock |
| cyc_write | input | 1 | Cycle type: 1 = write, 0 = read |
| cyc_addr | input | 32 | Cycle address |
| region_hit | output | 1 | One-clock hit pulse |

## Verification
A register write takes effect at the edge that samples it. Read-back is combinational, so the bench reads a register at the falling edge after the write. A bus cycle is driven at a falling edge and sampled at the next rising edge. Its hit is due in the half cycle after that edge, so the bench checks `region_hit` at the following falling edge. One falling edge later it checks that the pulse has dropped. Back-to-back cycles are checked at each falling edge in turn, which confirms one pulse per cycle with no gap and no stretching.

// File: rtl/region_match_pkg.sv
// Package: shared widths and field helpers for the region match detector.
// Assumes the compared field lies inside the address word.
package region_match_pkg;

    // Width of one address word and of each register.
    localparam int unsigned WORD_W = 32;

    // Builds a mask with ones in bit positions hi down to lo.
    function automatic logic [WORD_W-1:0] span_mask(input int unsigned hi, input int unsigned lo);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < WORD_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/region_match_regs.sv
// Module: base and mask register storage with reserved bits forced to zero.
// Assumes writes are single-cycle strobes; the read mux is combinational.
module region_match_regs
    import region_match_pkg::*;
#(
    parameter int unsigned FIELD_HI = 27,
    parameter int unsigned FIELD_LO = 2,
    parameter int unsigned WE_BIT   = 1,
    parameter int unsigned RE_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] base_q,
    output logic [WORD_W-1:0] mask_q,
    output logic              wr_allow,
    output logic              rd_allow
);

    localparam logic [WORD_W-1:0] BASE_KEEP = span_mask(FIELD_HI, FIELD_LO);
    localparam logic [WORD_W-1:0] MASK_KEEP = span_mask(FIELD_HI, 0);

    // Base register: only the compared field is writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                base_q <= '0;
        else if (wr_en && !sel)    base_q <= wdata & BASE_KEEP;
    end

    // Mask register: field plus the two cycle-type enables.
    always_ff @(posedge clk) begin
        if (!rst_n)                mask_q <= '0;
        else if (wr_en && sel)     mask_q <= wdata & MASK_KEEP;
    end

    // Read-back mux and enable extraction.
    always_comb begin
        rdata    = sel ? mask_q : base_q;
        wr_allow = mask_q[WE_BIT];
        rd_allow = mask_q[RE_BIT];
    end

    // R2: base only changes on a base write.
    a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !sel) |=> $stable(base_q));

    // R3: mask only changes on a mask write.
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel) |=> $stable(mask_q));

endmodule

// File: rtl/region_match_cmp.sv
// Module: masked address comparator over the programmable field.
// Assumes base holds zeros outside the field; bits outside it are ignored.
module region_match_cmp
    import region_match_pkg::*;
#(
    parameter int unsigned FIELD_HI = 27,
    parameter int unsigned FIELD_LO = 2
) (
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] mask,
    output logic              match
);

    localparam logic [WORD_W-1:0] CMP_FIELD = span_mask(FIELD_HI, FIELD_LO);

    logic [WORD_W-1:0] miss_bits;

    // Flag each field bit that differs and is not masked out.
    always_comb begin
        miss_bits = (addr ^ base) & ~mask & CMP_FIELD;
        match     = (miss_bits == '0);
    end

endmodule

// File: rtl/region_match_top.sv
// Module: top of the region match detector. Registers a one-clock hit
// for each valid bus cycle that matches the region and whose type is enabled.
// Assumes one bus cycle per clock while cyc_valid is high.
module region_match_top
    import region_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic [WORD_W-1:0] cyc_addr,
    output logic              region_hit
);

    localparam int unsigned FIELD_HI = 27;
    localparam int unsigned FIELD_LO = 2;

    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] mask_q;
    logic              wr_allow;
    logic              rd_allow;
    logic              addr_match;
    logic              type_ok;

    region_match_regs #(
        .FIELD_HI(FIELD_HI), .FIELD_LO(FIELD_LO), .WE_BIT(1), .RE_BIT(0)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .base_q(base_q),
        .mask_q(mask_q), .wr_allow(wr_allow), .rd_allow(rd_allow)
    );

    region_match_cmp #(
        .FIELD_HI(FIELD_HI), .FIELD_LO(FIELD_LO)
    ) i_cmp (
        .addr(cyc_addr), .base(base_q), .mask(mask_q), .match(addr_match)
    );

    // Cycle-type qualification.
    always_comb type_ok = cyc_write ? wr_allow : rd_allow;

    // Hit register: one pulse per qualifying valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) region_hit <= 1'b0;
        else        region_hit <= cyc_valid && addr_match && type_ok;
    end

    // R9: a hit always follows a valid cycle.
    a_r9_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        region_hit |-> $past(cyc_valid));

    // R6 and R7: a hit follows only an enabled cycle type.
    a_r6_r7_type_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        region_hit |-> ($past(cyc_write) ? $past(wr_allow) : $past(rd_allow)));

    // R4: a hit follows only an address that the comparator accepted.
    a_r4_hit_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        region_hit |-> $past(addr_match));

endmodule

// File: tb/test_region_match_top.sv
module test_region_match_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cyc_valid = 1'b0;
    logic        cyc_write = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        region_hit;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    region_match_top i_region_match_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_valid(cyc_valid),
        .cyc_write(cyc_write), .cyc_addr(cyc_addr), .region_hit(region_hit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_check(input string req, input logic sel, input logic [31:0] exp);
        @(negedge clk);
        reg_sel = sel;
        #1 check(req, reg_rdata, exp);
    endtask

    // One bus cycle; hit due at the next falling edge, gone one clock later.
    task automatic bus(input string req, input logic v, input logic w,
                       input logic [31:0] a, input logic exp);
        @(negedge clk);
        cyc_valid = v; cyc_write = w; cyc_addr = a;
        @(negedge clk);
        cyc_valid = 1'b0;
        check(req, {31'd0, region_hit}, {31'd0, exp});
        @(negedge clk);
        check({req, " pulse width"}, {31'd0, region_hit}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 hit low", {31'd0, region_hit}, 32'd0);
        reg_check("R1 base zero", 1'b0, 32'd0);
        reg_check("R1 mask zero", 1'b1, 32'd0);
        bus("R1 read no hit", 1'b1, 1'b0, 32'h0000_0000, 1'b0);
        bus("R1 write no hit", 1'b1, 1'b1, 32'h0000_0000, 1'b0);
    endtask

    task automatic t_regs;
        reg_write(1'b0, 32'hF123_4567);
        reg_check("R2 base reserved zero", 1'b0, 32'h0123_4564);
        reg_write(1'b1, 32'hFFFF_FFFF);
        reg_check("R3 mask reserved zero", 1'b1, 32'h0FFF_FFFF);
        reg_check("R2 base untouched by mask write", 1'b0, 32'h0123_4564);
    endtask

    task automatic t_exact;
        reg_write(1'b0, 32'h0040_0000);
        reg_write(1'b1, 32'h0000_0003);
        bus("R4 exact match", 1'b1, 1'b0, 32'h0040_0000, 1'b1);
        bus("R4 bit 2 differs", 1'b1, 1'b0, 32'h0040_0004, 1'b0);
        bus("R4 bit 27 differs", 1'b1, 1'b1, 32'h0840_0000, 1'b0);
        bus("R8 outer bits ignored", 1'b1, 1'b0, 32'hF040_0003, 1'b1);
    endtask

    task automatic t_mask;
        reg_write(1'b1, 32'h0000_0FFF);
        bus("R5 masked bits", 1'b1, 1'b0, 32'h0040_0ABC, 1'b1);
        bus("R4 unmasked bit differs", 1'b1, 1'b0, 32'h0041_0ABC, 1'b0);
    endtask

    task automatic t_types;
        reg_write(1'b1, 32'h0000_0001);
        bus("R7 read enabled", 1'b1, 1'b0, 32'h0040_0000, 1'b1);
        bus("R6 write disabled", 1'b1, 1'b1, 32'h0040_0000, 1'b0);
        reg_write(1'b1, 32'h0000_0002);
        bus("R6 write enabled", 1'b1, 1'b1, 32'h0040_0000, 1'b1);
        bus("R7 read disabled", 1'b1, 1'b0, 32'h0040_0000, 1'b0);
    endtask

    task automatic t_valid;
        reg_write(1'b1, 32'h0000_0003);
        bus("R9 no valid no hit", 1'b0, 1'b0, 32'h0040_0000, 1'b0);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_write = 1'b0; cyc_addr = 32'h0040_0000;
        @(negedge clk);
        check("R9 back-to-back first", {31'd0, region_hit}, 32'd1);
        @(negedge clk);
        cyc_valid = 1'b0;
        check("R9 back-to-back second", {31'd0, region_hit}, 32'd1);
        @(negedge clk);
        check("R9 back-to-back end", {31'd0, region_hit}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_exact;
        t_mask;
        t_types;
        t_valid;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule